// File: doc/BRIEF.md
# One-Time-Programmable Security Zone Access Guard

This block stands between a bus requester and a 1024-byte fuse array model. Each request is a single byte. It carries an address, a write flag, a secure/non-secure attribute and, for writes, a data byte. The guard decides whether the request may touch the array. It bases that decision on protection bits that live in the array itself, in four configuration bytes. Key slots can be read-protected or write-locked. Two user areas can be closed to non-secure requesters. All other locations are always open.

Every fuse starts at 1, and programming can only move a bit from 1 to 0. A granted write therefore stores the old byte ANDed with the new byte. A protection bit is active when it reads 0. The guard copies the four configuration bytes into a register on the first cycle after reset release. It reloads them one cycle after any granted write to those bytes. A bit that has been cleared can never come back.

Requests use a valid/ready handshake. The response arrives on the following cycle and carries a data byte and an error flag. A denied read returns 0x00 with the error flag set. A denied write leaves the array unchanged and also sets the error flag.

Top module: `otp_secure_guard`

## Requirements
- R1: Every array byte reads 0xFF until it is written. reqReady is low during reset and on the first cycle after reset release, and high from then on.
- R2: A granted write stores (old byte AND write byte), so a bit can never go from 0 back to 1.
- R3: An accepted request gives exactly one rspValid pulse on the next cycle, and no other cycle has rspValid. A granted read returns the stored byte. A write returns rspRdata 0x00.
- R4: The protection word is formed from bytes 0x364..0x367, with 0x364 as the least significant byte. Key slot k (k = 0..7, 32 bytes at 0x200 + 32k) is write-locked when word bit 12+2k is 0.
- R5: Key slot k is read-protected when word bit 11+2k is 0. A denied read returns 0x00 with rspErr = 1.
- R6: For the debug password (0x300..0x30F), reads are blocked by word bit 5 and writes by bit 6. Writes are blocked by bit 7 for the unique key (0x310..0x31F), by bit 9 for hash 0 (0x320..0x33F) and by bit 10 for hash 1 (0x340..0x35F). In each case the bit blocks when it is 0.
- R7: When word bit 30 is 0, non-secure reads and writes to 0x380..0x3BF are denied. Word bit 31 does the same for 0x3C0..0x3FF. Secure requests to these areas are always granted.
- R8: A denied write sets rspErr and leaves the target byte unchanged.
- R9: A request accepted in the cycle right after a granted write to 0x364..0x367 is checked against the old protection. From the cycle after that, the new value applies.
- R10: Protection bits are reloaded from the array at reset release, so they stay in force across a reset.
- R11: Addresses 0x000..0x1FF and 0x360..0x37F are granted for both reads and writes, whatever the secure attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Guard can accept a request |
| reqAddr | input | ADDR_W | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSecure | input | 1 | 1 = secure requester |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | Response present (one cycle after accept) |
| rspRdata | output | 8 | Read byte, 0x00 on writes and denials |
| rspErr | output | 1 | Request was denied |

## Verification
Two things can happen in the same cycle: the protection register reloads after a write to a configuration byte, and a new request has its permission checked. The bench writes a configuration byte that locks a key slot. It then issues a write to that slot in the very next cycle, which must still be granted. It follows with a second write one cycle later, which must be denied. The bench's reference model marks when each reload takes effect by counting edges, so the pass/fail outcome of each request is predicted on its own. A later readback shows which of the two writes actually reached the array.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;
  localparam int unsigned BYTE_W       = 8;
  // region map (byte addresses)
  localparam int unsigned KEY_BASE     = 'h200;
  localparam int unsigned SLOT_BYTES   = 32;
  localparam int unsigned PWD_BASE     = 'h300;
  localparam int unsigned UKEY_BASE    = 'h310;
  localparam int unsigned SMALL_BYTES  = 16;
  localparam int unsigned HASH0_BASE   = 'h320;
  localparam int unsigned HASH1_BASE   = 'h340;
  localparam int unsigned HASH_BYTES   = 32;
  localparam int unsigned PROT_BASE    = 'h364;
  localparam int unsigned PROT_BYTES   = 4;
  localparam int unsigned USER_LO_BASE = 'h380;
  localparam int unsigned USER_HI_BASE = 'h3C0;
  localparam int unsigned USER_BYTES   = 64;
  localparam int unsigned PROT_W       = PROT_BYTES * BYTE_W;
  // bit positions inside the protection word (0 = protection active)
  localparam int unsigned PWD_RD_BIT   = 5;
  localparam int unsigned PWD_WR_BIT   = 6;
  localparam int unsigned UKEY_WR_BIT  = 7;
  localparam int unsigned HASH0_WR_BIT = 9;
  localparam int unsigned HASH1_WR_BIT = 10;
  localparam int unsigned SLOT_RD_BIT0 = 11;
  localparam int unsigned USER_LO_BIT  = 30;
  localparam int unsigned USER_HI_BIT  = 31;

  typedef struct packed {
    logic accept;
    logic wrEn;
    logic rdEn;
    logic deny;
  } guardStrobe_t;
endpackage

// File: rtl/otp_guard_ctrl.sv
module otp_guard_ctrl
  import otp_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned KEY_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic [PROT_W-1:0] cfgWord,
  output logic [PROT_W-1:0] protBits,
  output guardStrobe_t      strobe
);
  logic              bootPending;
  logic              refreshPending;
  logic [PROT_W-1:0] protQ;
  logic [31:0]       addr32;

  assign addr32 = {{(32-ADDR_W){1'b0}}, reqAddr};

  function automatic logic inRange(logic [31:0] a, int unsigned base, int unsigned len);
    return (a >= base) && (a < base + len);
  endfunction

  // per-slot decode of the key area
  logic [KEY_SLOTS-1:0] slotRdBlk;
  logic [KEY_SLOTS-1:0] slotWrBlk;
  for (genvar k = 0; k < KEY_SLOTS; k++) begin : g_slot
    localparam int unsigned SLOT_LO = KEY_BASE + k * SLOT_BYTES;
    localparam int unsigned RD_BIT  = SLOT_RD_BIT0 + 2 * k;
    localparam int unsigned WR_BIT  = RD_BIT + 1;
    logic slotHit;
    assign slotHit      = inRange(addr32, SLOT_LO, SLOT_BYTES);
    assign slotRdBlk[k] = slotHit & ~protQ[RD_BIT];
    assign slotWrBlk[k] = slotHit & ~protQ[WR_BIT];
  end

  logic pwdHit, ukeyHit, hash0Hit, hash1Hit, userLoHit, userHiHit, cfgHit;
  assign pwdHit    = inRange(addr32, PWD_BASE, SMALL_BYTES);
  assign ukeyHit   = inRange(addr32, UKEY_BASE, SMALL_BYTES);
  assign hash0Hit  = inRange(addr32, HASH0_BASE, HASH_BYTES);
  assign hash1Hit  = inRange(addr32, HASH1_BASE, HASH_BYTES);
  assign userLoHit = inRange(addr32, USER_LO_BASE, USER_BYTES);
  assign userHiHit = inRange(addr32, USER_HI_BASE, USER_BYTES);
  assign cfgHit    = inRange(addr32, PROT_BASE, PROT_BYTES);

  logic userBlk, rdBlock, wrBlock, denied, accept;
  assign userBlk = ~reqSecure & ((userLoHit & ~protQ[USER_LO_BIT]) |
                                 (userHiHit & ~protQ[USER_HI_BIT]));
  assign rdBlock = (|slotRdBlk) | (pwdHit & ~protQ[PWD_RD_BIT]) | userBlk;
  assign wrBlock = (|slotWrBlk) | (pwdHit & ~protQ[PWD_WR_BIT])
                 | (ukeyHit  & ~protQ[UKEY_WR_BIT])
                 | (hash0Hit & ~protQ[HASH0_WR_BIT])
                 | (hash1Hit & ~protQ[HASH1_WR_BIT]) | userBlk;
  assign denied  = reqWrite ? wrBlock : rdBlock;

  assign reqReady = ~bootPending;
  assign accept   = reqValid & reqReady;

  always_comb begin
    strobe.accept = accept;
    strobe.wrEn   = accept & reqWrite & ~denied;
    strobe.rdEn   = accept & ~reqWrite & ~denied;
    strobe.deny   = accept & denied;
  end

  // protection copy: boot load, then AND-refresh after configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      bootPending    <= 1'b1;
      refreshPending <= 1'b0;
      protQ          <= '0;
    end else begin
      refreshPending <= accept & reqWrite & ~denied & cfgHit;
      if (bootPending) begin
        protQ       <= cfgWord;
        bootPending <= 1'b0;
      end else if (refreshPending) begin
        protQ <= protQ & cfgWord;
      end
    end
  end

  assign protBits = protQ;
endmodule

// File: rtl/otp_guard_datapath.sv
module otp_guard_datapath
  import otp_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  guardStrobe_t      strobe,
  output logic [PROT_W-1:0] cfgWord,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspRdata,
  output logic              rspErr
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  // unprogrammed fuses read as all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  // fuse programming can only clear bits; the array ignores reset
  always_ff @(posedge clk) begin
    if (strobe.wrEn) cells[addr] <= cells[addr] & wdata;
  end

  for (genvar b = 0; b < PROT_BYTES; b++) begin : g_cfg
    assign cfgWord[b*BYTE_W +: BYTE_W] = cells[ADDR_W'(PROT_BASE + b)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.accept;
      rspErr   <= strobe.deny;
      rspRdata <= strobe.rdEn ? cells[addr] : '0;
    end
  end
endmodule

// File: rtl/otp_secure_guard.sv
module otp_secure_guard
  import otp_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned KEY_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic [BYTE_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspRdata,
  output logic              rspErr
);
  guardStrobe_t      strobe;
  logic [PROT_W-1:0] cfgWord;
  logic [PROT_W-1:0] protBits;

  otp_guard_ctrl #(.ADDR_W(ADDR_W), .KEY_SLOTS(KEY_SLOTS)) ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .cfgWord(cfgWord), .protBits(protBits), .strobe(strobe)
  );

  otp_guard_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .addr(reqAddr), .wdata(reqWdata), .strobe(strobe),
    .cfgWord(cfgWord), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );
endmodule

// File: rtl/otp_secure_guard_chk.sv
module otp_secure_guard_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqSecure,
  input logic              rspValid,
  input logic [7:0]        rspRdata,
  input logic              rspErr,
  input logic [31:0]       protBits
);
  logic [31:0] addr32;
  assign addr32 = {{(32-ADDR_W){1'b0}}, reqAddr};

  // R1: once ready after reset, ready stays up
  p_ready_holds_r1: assert property (@(posedge clk) disable iff (rst)
    reqReady |=> reqReady);

  // R3: one response per accepted request, none otherwise
  p_rsp_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> rspValid);
  p_no_spurious_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && reqReady) |=> !rspValid);

  // R3: writes return a zero data byte
  p_write_rdata_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqWrite) |=> (rspRdata == 8'h00));

  // R5: a denied response never leaks data
  p_denied_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspErr) |-> (rspRdata == 8'h00));

  // R7: closed lower user area refuses non-secure requesters
  p_user_lo_closed_r7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqSecure && addr32 >= 32'h380 && addr32 < 32'h3C0
     && !protBits[30]) |=> rspErr);

  // R4: locked key slot 0 refuses writes
  p_slot0_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqWrite && addr32 >= 32'h200 && addr32 < 32'h220
     && !protBits[12]) |=> rspErr);

  // R9: protection bits, once in force, only ever clear
  p_prot_monotonic_r9: assert property (@(posedge clk) disable iff (rst)
    (reqReady && $past(reqReady)) |-> ((protBits & ~$past(protBits)) == 32'h0));
endmodule

bind otp_secure_guard otp_secure_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSecure(reqSecure),
  .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr), .protBits(protBits)
);

// File: tb/otp_secure_guard_tb_top.sv
module otp_secure_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [9:0] reqAddr = '0;
  logic       reqWrite = 1'b0;
  logic       reqSecure = 1'b0;
  logic [7:0] reqWdata = '0;
  logic       rspValid;
  logic [7:0] rspRdata;
  logic       rspErr;

  always #10 clk = ~clk;

  otp_secure_guard dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  typedef struct {
    logic [7:0] data;
    logic       err;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  int         compared = 0;
  int         mismatched = 0;
  longint     cyc = 0;
  bit         finished = 0;
  logic [7:0] shadow [1024];
  logic [31:0] protM;
  bit         refPend = 0;
  longint     refAt = 0;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] shadowWord();
    return {shadow['h367], shadow['h366], shadow['h365], shadow['h364]};
  endfunction

  function automatic bit isBlocked(int a, bit wr, bit sec, logic [31:0] p);
    bit rdB = 0;
    bit wrB = 0;
    if (a >= 'h200 && a < 'h300) begin
      int k = (a - 'h200) / 32;
      rdB = !p[11 + 2*k];
      wrB = !p[12 + 2*k];
    end else if (a >= 'h300 && a < 'h310) begin
      rdB = !p[5]; wrB = !p[6];
    end else if (a >= 'h310 && a < 'h320) begin
      wrB = !p[7];
    end else if (a >= 'h320 && a < 'h340) begin
      wrB = !p[9];
    end else if (a >= 'h340 && a < 'h360) begin
      wrB = !p[10];
    end else if (a >= 'h380 && a < 'h3C0 && !sec) begin
      rdB = !p[30]; wrB = !p[30];
    end else if (a >= 'h3C0 && !sec) begin
      rdB = !p[31]; wrB = !p[31];
    end
    return wr ? wrB : rdB;
  endfunction

  task automatic check(bit ok, string what, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, expv);
    end
  endtask

  // driver: computes the expected response and pushes it before the accepting edge
  task automatic issue(int a, bit wr, bit sec, logic [7:0] d, string tag);
    expItem_t e;
    bit blk;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    if (refPend && (cyc + 1 > refAt)) begin
      protM   = protM & shadowWord();
      refPend = 0;
    end
    blk   = isBlocked(a, wr, sec, protM);
    e.tag = tag;
    e.err = blk;
    if (wr) begin
      e.data = 8'h00;
      if (!blk) begin
        shadow[a] = shadow[a] & d;
        if (a >= 'h364 && a < 'h368) begin
          refPend = 1;
          refAt   = cyc + 2;
        end
      end
    end else begin
      e.data = blk ? 8'h00 : shadow[a];
    end
    expQ.push_back(e);
    reqValid  = 1'b1;
    reqAddr   = 10'(a);
    reqWrite  = wr;
    reqSecure = sec;
    reqWdata  = d;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares every response
  always @(negedge clk) begin
    if (!rst && rspValid) begin
      if (expQ.size() == 0) begin
        check(0, "R3 response with nothing outstanding", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rspErr == e.err, {e.tag, " err"}, rspErr, e.err);
        check(rspRdata == e.data, {e.tag, " data"}, rspRdata, e.data);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(reqReady == 1'b0, "R1 ready low right after reset release", reqReady, 0);
    protM   = shadowWord();
    refPend = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready high one cycle after release", reqReady, 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish();
  end

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = 8'hFF;
    doReset();

    // R1 erased state, R3 read path
    issue('h000, 0, 0, 8'h00, "R1 erased 0x000");
    issue('h200, 0, 0, 8'h00, "R1 erased key slot 0");
    issue('h3FF, 0, 0, 8'h00, "R1 erased 0x3FF");
    // R2 AND semantics, R11 lower zone open to non-secure
    issue('h010, 1, 0, 8'h5A, "R11 lower zone write");
    issue('h010, 1, 1, 8'hF0, "R2 second write");
    issue('h010, 0, 0, 8'h00, "R2 readback 0x50");
    issue('h370, 1, 0, 8'h30, "R11 config area write");
    issue('h370, 0, 1, 8'h00, "R11 config area read");
    issue('h380, 0, 0, 8'h00, "R7 user area open by default");
    issue('h260, 1, 0, 8'h12, "R4 key3 write while unlocked");
    issue('h260, 0, 0, 8'h00, "R4 key3 readback");
    idle(1);

    // R9: lock key3, then same-window and next-window writes
    issue('h366, 1, 0, 8'hFB, "R9 lock key3 write");
    issue('h261, 1, 0, 8'h00, "R9 write in refresh window granted");
    issue('h262, 1, 0, 8'h00, "R4 write after refresh denied");
    issue('h262, 0, 0, 8'h00, "R8 denied write left 0xFF");
    issue('h261, 0, 0, 8'h00, "R9 window write landed");
    idle(2);

    // R5: read-protect key slot 0 (word bit 11 = byte 0x365 bit 3)
    issue('h365, 1, 0, 8'hF7, "R5 set key0 read protect");
    idle(2);
    issue('h200, 0, 1, 8'h00, "R5 key0 read denied");
    issue('h200, 1, 0, 8'h0F, "R5 key0 still writable");
    idle(2);

    // R6: password read/write, unique key, hashes
    issue('h364, 1, 0, 8'h9F, "R6 lock password");
    idle(2);
    issue('h305, 0, 1, 8'h00, "R6 password read denied");
    issue('h305, 1, 1, 8'h00, "R6 password write denied");
    issue('h364, 1, 0, 8'h7F, "R6 lock unique key");
    idle(2);
    issue('h315, 1, 0, 8'h00, "R6 unique key write denied");
    issue('h315, 0, 0, 8'h00, "R6 unique key read open");
    issue('h365, 1, 0, 8'hF9, "R6 lock both hashes");
    idle(2);
    issue('h320, 1, 1, 8'h00, "R6 hash0 write denied");
    issue('h34F, 1, 1, 8'h00, "R6 hash1 write denied");
    issue('h320, 0, 0, 8'h00, "R6 hash0 read open");
    idle(2);

    // R7: close lower user area to non-secure
    issue('h367, 1, 0, 8'hBF, "R7 close lower user area");
    idle(2);
    issue('h380, 0, 0, 8'h00, "R7 non-secure read denied");
    issue('h380, 0, 1, 8'h00, "R7 secure read granted");
    issue('h3C0, 0, 0, 8'h00, "R7 upper area still open");
    issue('h3BF, 1, 0, 8'h00, "R7 non-secure write denied");
    issue('h3BF, 1, 1, 8'h33, "R7 secure write granted");
    issue('h3BF, 0, 1, 8'h00, "R7 secure readback");
    idle(2);

    // R2: attempt to set a cleared protection bit
    issue('h366, 1, 0, 8'hFF, "R2 try to restore key3 lock bit");
    idle(2);
    issue('h366, 0, 0, 8'h00, "R2 protection byte unchanged");
    issue('h263, 1, 0, 8'h00, "R4 key3 still locked");
    idle(2);

    // R10: protection survives reset
    doReset();
    issue('h200, 0, 1, 8'h00, "R10 key0 read protect after reset");
    issue('h380, 0, 0, 8'h00, "R10 user area closed after reset");
    issue('h010, 0, 0, 8'h00, "R10 array contents kept");
    idle(4);

    check(expQ.size() == 0, "R3 all responses received", expQ.size(), 0);
    finish();
  end
endmodule